// File: doc/BRIEF.md
# Trigger-gated hit latch pipeline

The block watches 32 discriminated wire-chamber channels. It records their on/off state on every rising edge of the beam RF clock, which runs at about 53 MHz. The samples go into two 16-bit circular history banks, so the block always keeps the last 1024 clocks of hit patterns. A first-level trigger, when the gate input allows it, picks the snapshot from a programmable number of clocks back. The trigger also gives the event an 11-bit event number. The event is then held in a five-deep pending queue while the slower second-level decision is made.

A second-level accept takes the oldest pending event, reduces it to a zero-suppressed word list and writes that list into a 2048-word event memory. A fast clear discards the oldest pending event. An event that gets no decision within a fixed wait also expires. The host drains the event memory one word per read strobe. A word-count output and a full flag show how much data is stored.

Top module: `hlp_top`

## Requirements
- R1: After a synchronous reset, word_count_o is 0, full_o is 0, rd_valid_o is 0, rej_count_o is 0, the latency is 5 clocks and the next event number is 0.
- R2: A first-level trigger accepted at clock edge e captures the 32 hit inputs that were sampled at edge e−L, where L is the latency. Writing lat_val_i with lat_we_i sets L from the next edge on. A written value of 0 is taken as 1.
- R3: A committed event is stored as one hit word per set channel, in ascending channel order, followed by one trailer word. A hit word has bit 31 = 0, bits 26:16 = event number and bits 4:0 = channel. A trailer has bit 31 = 1, bits 26:16 = event number and bits 5:0 = number of hits. All other bits are 0.
- R4: Each accepted first-level trigger takes the next event number, modulo 2048, whether or not the event is later committed.
- R5: A second-level accept commits the oldest pending event, so events leave in trigger order. Accepts are acted on only while no commit is in progress.
- R6: A fast clear removes the oldest pending event without writing anything, and takes priority over an accept in the same cycle.
- R7: A pending event that gets no decision within L2_WAIT clocks (default 64) of entering the queue is dropped without writing anything.
- R8: A trigger while gate_i is low is ignored and increments rej_count_o by one.
- R9: A trigger that would make more than 5 events pending, counting an event still being captured, is ignored and increments rej_count_o by one.
- R10: A read strobe while word_count_o is non-zero returns the oldest stored word on rd_data_o with rd_valid_o high on the next clock, and decrements word_count_o. A strobe while the memory is empty gives no rd_valid_o.
- R11: full_o is high exactly when fewer than 33 words are free (word_count_o > 2015). An accept taken while full_o is high drops the event and writes nothing.
- R12: An event with no hits in its snapshot is committed as a lone trailer with a hit count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam RF sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | 32 | Discriminated channel states |
| gate_i | input | 1 | Enables first-level triggers |
| l1_trig_i | input | 1 | First-level trigger |
| l2_accept_i | input | 1 | Second-level accept for the oldest pending event |
| fast_clear_i | input | 1 | Discard the oldest pending event |
| lat_we_i | input | 1 | Latency write strobe |
| lat_val_i | input | 10 | Latency value in clocks |
| rd_strobe_i | input | 1 | Read one word from the event memory |
| rd_data_o | output | 32 | Word returned for a read strobe |
| rd_valid_o | output | 1 | rd_data_o holds a word this cycle |
| word_count_o | output | 12 | Words held in the event memory |
| full_o | output | 1 | Event memory cannot take a maximum-size event |
| rej_count_o | output | 16 | Ignored first-level triggers |

## Verification
The hardest state to reach is the full boundary. The memory only stops taking events after dozens of commits, with the count near the 33-word margin. The stimulus holds all 32 hit lines high so that each commit writes exactly 33 words. It commits 62 events, offers a 63rd that must be dropped, and then reads back across the threshold one word at a time. A second hard case is the pending-queue limit with a capture still in flight. Six triggers on back-to-back edges make only the sixth one find the queue full.

// File: rtl/hlp_pkg.sv
package hlp_pkg;
  localparam int NCH    = 32;
  localparam int CH_W   = $clog2(NCH);
  localparam int EV_W   = 11;
  localparam int HCNT_W = CH_W + 1;
  localparam int TS_W   = 16;

  typedef struct packed {
    logic [NCH-1:0]  mask;
    logic [EV_W-1:0] ev;
    logic [TS_W-1:0] ts;
  } pend_t;

  function automatic logic [31:0] hit_word(input logic [EV_W-1:0] ev, input logic [CH_W-1:0] ch);
    hit_word = {1'b0, 4'b0, ev, 11'b0, ch};
  endfunction

  function automatic logic [31:0] trailer_word(input logic [EV_W-1:0] ev, input logic [HCNT_W-1:0] n);
    trailer_word = {1'b1, 4'b0, ev, 10'b0, n};
  endfunction

  function automatic logic [CH_W-1:0] lowest_ch(input logic [NCH-1:0] m);
    lowest_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) lowest_ch = CH_W'(i);
    end
  endfunction

  function automatic logic [HCNT_W-1:0] hit_total(input logic [NCH-1:0] m);
    hit_total = '0;
    for (int i = 0; i < NCH; i++) hit_total = hit_total + HCNT_W'(m[i]);
  endfunction
endpackage

// File: rtl/hlp_hist_bank.sv
module hlp_hist_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Read returns the old contents; the write slot never equals the read slot.
  always_ff @(posedge clk) begin
    mem[wr_addr] <= wr_data;
    rd_data      <= mem[rd_addr];
  end
endmodule

// File: rtl/hlp_hit_history.sv
module hlp_hit_history
  import hlp_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int NHALF   = 2,
  parameter int LAT_RST = 5,
  localparam int AW     = $clog2(DEPTH),
  localparam int HALF_W = NCH / NHALF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] hits,
  input  logic           lat_we,
  input  logic [AW-1:0]  lat_val,
  output logic [NCH-1:0] snap
);
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] lat_q;
  logic [AW-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      lat_q  <= AW'(LAT_RST);
    end else begin
      wptr_q <= wptr_q + 1'b1;
      if (lat_we) lat_q <= (lat_val == '0) ? AW'(1) : lat_val;
    end
  end

  assign rd_addr = wptr_q - lat_q;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    hlp_hist_bank #(.W(HALF_W), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_addr (wptr_q),
      .wr_data (hits[g*HALF_W +: HALF_W]),
      .rd_addr (rd_addr),
      .rd_data (snap[g*HALF_W +: HALF_W])
    );
  end

  AST_LAT_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    lat_we |=> (lat_q != '0)); // R2
endmodule

// File: rtl/hlp_pend_fifo.sv
module hlp_pend_fifo
  import hlp_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  pend_t         push_data,
  input  logic          pop,
  output pend_t         head,
  output logic [CW-1:0] count,
  output logic          empty
);
  pend_t         slots [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    nxt = (int'(i) == DEPTH - 1) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[tail_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= nxt(tail_q);
      if (pop)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head  = slots[head_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

  AST_PEND_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(push && !pop && int'(cnt_q) == DEPTH)); // R9
  AST_PEND_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(pop && cnt_q == '0)); // R5
endmodule

// File: rtl/hlp_zs_encoder.sv
module hlp_zs_encoder
  import hlp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [NCH-1:0]  mask,
  input  logic [EV_W-1:0] ev,
  output logic            busy,
  output logic            wr_v,
  output logic [31:0]     wr_word
);
  logic [NCH-1:0]    mask_q;
  logic [EV_W-1:0]   ev_q;
  logic [HCNT_W-1:0] n_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      ev_q   <= '0;
      n_q    <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      mask_q <= mask;
      ev_q   <= ev;
      n_q    <= hit_total(mask);
    end else if (busy_q) begin
      if (mask_q != '0) mask_q <= mask_q & (mask_q - 1'b1);
      else              busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign wr_v    = busy_q;
  assign wr_word = (mask_q != '0) ? hit_word(ev_q, lowest_ch(mask_q))
                                  : trailer_word(ev_q, n_q);

  AST_TRAILER_ENDS: assert property (@(posedge clk) disable iff (rst)
    (wr_v && wr_word[31] && !load) |=> !busy); // R3
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(load && busy_q)); // R5
endmodule

// File: rtl/hlp_event_store.sv
module hlp_event_store #(
  parameter int DEPTH = 2048,
  parameter int MAXW  = 33,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_v,
  input  logic [31:0]   wr_word,
  input  logic          rd_strobe,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [CW-1:0] count,
  output logic          full
);
  localparam logic [CW-1:0] FULL_AT = CW'(DEPTH - MAXW);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          rd_go;

  assign rd_go = rd_strobe && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (wr_v) mem[wptr_q] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (wr_v) wptr_q <= wptr_q + 1'b1;
      if (rd_go) begin
        rptr_q  <= rptr_q + 1'b1;
        rd_data <= mem[rptr_q];
      end
      rd_valid <= rd_go;
      cnt_q    <= cnt_q + CW'(wr_v) - CW'(rd_go);
    end
  end

  assign count = cnt_q;
  assign full  = (cnt_q > FULL_AT);

  AST_EVM_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(wr_v && !rd_go && int'(cnt_q) == DEPTH)); // R11
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && cnt_q != '0) |=> rd_valid); // R10
  AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && cnt_q == '0) |=> !rd_valid); // R10
endmodule

// File: rtl/hlp_top.sv
module hlp_top
  import hlp_pkg::*;
#(
  parameter int HIST_DEPTH = 1024,
  parameter int EVM_DEPTH  = 2048,
  parameter int PEND_DEPTH = 5,
  parameter int L2_WAIT    = 64,
  parameter int LAT_RST    = 5,
  parameter int RCNT_W     = 16,
  localparam int LAT_W     = $clog2(HIST_DEPTH),
  localparam int WC_W      = $clog2(EVM_DEPTH) + 1,
  localparam int MAXW      = NCH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    hit_i,
  input  logic              gate_i,
  input  logic              l1_trig_i,
  input  logic              l2_accept_i,
  input  logic              fast_clear_i,
  input  logic              lat_we_i,
  input  logic [LAT_W-1:0]  lat_val_i,
  input  logic              rd_strobe_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic [WC_W-1:0]   word_count_o,
  output logic              full_o,
  output logic [RCNT_W-1:0] rej_count_o
);
  localparam int PCW = $clog2(PEND_DEPTH + 1);

  // Named internal events, visible to the assertions.
  logic            trig_ok, trig_rej;
  logic            take_clear, take_accept, drop_timeout, enc_load, pend_pop;
  logic            timed_out;

  logic [NCH-1:0]    snap;
  logic              cap_v_q;
  logic [EV_W-1:0]   cap_ev_q, ev_cnt_q;
  logic [TS_W-1:0]   now_q;
  logic [RCNT_W-1:0] rej_q;

  pend_t          push_data, head;
  logic [PCW-1:0] pend_cnt;
  logic           pend_empty;
  logic           enc_busy, enc_wr_v;
  logic [31:0]    enc_word;

  hlp_hit_history #(.DEPTH(HIST_DEPTH), .NHALF(2), .LAT_RST(LAT_RST)) u_hist (
    .clk     (clk),
    .rst     (rst),
    .hits    (hit_i),
    .lat_we  (lat_we_i),
    .lat_val (lat_val_i),
    .snap    (snap)
  );

  // A capture in flight already owns a queue slot.
  assign trig_ok  = l1_trig_i && gate_i && (int'(pend_cnt) + int'(cap_v_q) < PEND_DEPTH);
  assign trig_rej = l1_trig_i && !trig_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v_q  <= 1'b0;
      cap_ev_q <= '0;
      ev_cnt_q <= '0;
      now_q    <= '0;
      rej_q    <= '0;
    end else begin
      now_q   <= now_q + 1'b1;
      cap_v_q <= trig_ok;
      if (trig_ok) begin
        cap_ev_q <= ev_cnt_q;
        ev_cnt_q <= ev_cnt_q + 1'b1;
      end
      if (trig_rej) rej_q <= rej_q + 1'b1;
    end
  end

  assign push_data = '{mask: snap, ev: cap_ev_q, ts: now_q};

  hlp_pend_fifo #(.DEPTH(PEND_DEPTH)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .push      (cap_v_q),
    .push_data (push_data),
    .pop       (pend_pop),
    .head      (head),
    .count     (pend_cnt),
    .empty     (pend_empty)
  );

  // Second-level decision on the oldest pending event.
  assign timed_out    = !pend_empty && ((now_q - head.ts) >= TS_W'(L2_WAIT));
  assign take_clear   = !pend_empty && !enc_busy && fast_clear_i;
  assign take_accept  = !pend_empty && !enc_busy && !fast_clear_i && l2_accept_i;
  assign enc_load     = take_accept && !full_o;
  assign drop_timeout = timed_out && !take_clear && !take_accept;
  assign pend_pop     = take_clear || take_accept || drop_timeout;

  hlp_zs_encoder u_enc (
    .clk     (clk),
    .rst     (rst),
    .load    (enc_load),
    .mask    (head.mask),
    .ev      (head.ev),
    .busy    (enc_busy),
    .wr_v    (enc_wr_v),
    .wr_word (enc_word)
  );

  hlp_event_store #(.DEPTH(EVM_DEPTH), .MAXW(MAXW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_v      (enc_wr_v),
    .wr_word   (enc_word),
    .rd_strobe (rd_strobe_i),
    .rd_data   (rd_data_o),
    .rd_valid  (rd_valid_o),
    .count     (word_count_o),
    .full      (full_o)
  );

  assign rej_count_o = rej_q;

  AST_GATE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (l1_trig_i && !gate_i) |=> (rej_count_o == RCNT_W'($past(rej_count_o) + 1'b1))); // R8
  AST_CLEAR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    take_clear |=> !enc_wr_v); // R6
  AST_FULL_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (take_accept && full_o) |=> !enc_wr_v); // R11
  AST_TIMEOUT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (drop_timeout && !enc_busy) |=> !enc_wr_v); // R7
endmodule

// File: tb/tb_hlp_top.sv
module tb_hlp_top;
  localparam int CLK_NS  = 10;
  localparam int EVM     = 2048;
  localparam int MAXW    = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] hit_i = '0;
  logic        gate_i = 1'b0, l1_trig_i = 1'b0, l2_accept_i = 1'b0, fast_clear_i = 1'b0;
  logic        lat_we_i = 1'b0;
  logic [9:0]  lat_val_i = '0;
  logic        rd_strobe_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic [11:0] word_count_o;
  logic        full_o;
  logic [15:0] rej_count_o;

  always #(CLK_NS/2) clk = ~clk;

  hlp_top dut (
    .clk(clk), .rst(rst), .hit_i(hit_i), .gate_i(gate_i), .l1_trig_i(l1_trig_i),
    .l2_accept_i(l2_accept_i), .fast_clear_i(fast_clear_i), .lat_we_i(lat_we_i),
    .lat_val_i(lat_val_i), .rd_strobe_i(rd_strobe_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .word_count_o(word_count_o), .full_o(full_o),
    .rej_count_o(rej_count_o)
  );

  typedef struct packed { logic [31:0] m; logic [10:0] ev; } pev_t;

  int          n_chk = 0, n_fail = 0;
  int          ecnt = 0;
  int          lat_tb = 5;
  int          exp_count = 0;
  int          rej_tb = 0;
  logic [10:0] ev_tb = '0;
  bit          fixed_mode = 1'b0;
  logic [31:0] fixed_val = '0;
  bit          done = 1'b0;
  logic [31:0] hist_tb [int];
  pev_t        pend_q [$];
  logic [31:0] sb_q [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int n);
    logic [31:0] v;
    v = 32'(n) * 32'h9E37_79B1;
    return v ^ (v >> 13) ^ 32'(n << 3);
  endfunction

  // One clock: record the sample taken at this edge, then move to the next low phase.
  task automatic cyc();
    hist_tb[ecnt] = hit_i;
    @(posedge clk);
    ecnt++;
    @(negedge clk);
    hit_i = fixed_mode ? fixed_val : gen(ecnt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic trig(input bit expect_ok);
    pev_t p;
    gate_i = 1'b1; l1_trig_i = 1'b1;
    if (expect_ok) begin
      p.m  = hist_tb[ecnt - lat_tb];
      p.ev = ev_tb;
      pend_q.push_back(p);
      ev_tb++;
    end else rej_tb++;
    cyc();
    l1_trig_i = 1'b0;
  endtask

  // Driver side of the scoreboard: expected words for a committed event.
  task automatic accept();
    pev_t p;
    int   n;
    l2_accept_i = 1'b1;
    if (pend_q.size() != 0) begin
      p = pend_q.pop_front();
      if (exp_count <= EVM - MAXW) begin
        n = 0;
        for (int i = 0; i < 32; i++) begin
          if (p.m[i]) begin
            sb_q.push_back({1'b0, 4'b0, p.ev, 11'b0, 5'(i)});
            n++;
          end
        end
        sb_q.push_back({1'b1, 4'b0, p.ev, 10'b0, 6'(n)});
        exp_count += n + 1;
      end
    end
    cyc();
    l2_accept_i = 1'b0;
  endtask

  task automatic fclear();
    fast_clear_i = 1'b1;
    if (pend_q.size() != 0) void'(pend_q.pop_front());
    cyc();
    fast_clear_i = 1'b0;
  endtask

  task automatic rd();
    rd_strobe_i = 1'b1;
    if (exp_count > 0) exp_count--;
    cyc();
    rd_strobe_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_count > 0) rd();
    idle(2);
  endtask

  task automatic set_lat(input int v);
    lat_we_i = 1'b1; lat_val_i = 10'(v);
    cyc();
    lat_we_i = 1'b0;
    lat_tb = (v == 0) ? 1 : v;
  endtask

  // Monitor side of the scoreboard (R3, R10).
  always @(negedge clk) begin
    if (!rst && rd_valid_o) begin
      if (sb_q.size() == 0) chk("R10 unexpected word", rd_data_o, 32'hxxxx_xxxx);
      else chk("R3 stored word", rd_data_o, sb_q.pop_front());
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    hit_i = gen(0);
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1
    chk("R1 word count", 32'(word_count_o), 0);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 rd_valid", 32'(rd_valid_o), 0);
    chk("R1 rejected", 32'(rej_count_o), 0);
    idle(20);

    // R2 default latency, R3/R4/R5 ordering and format
    for (int k = 0; k < 3; k++) begin
      trig(1'b1); idle(2); accept(); idle(40);
    end
    chk("R5 words after commits", 32'(word_count_o), 32'(exp_count));
    drain();
    chk("R10 drained", 32'(word_count_o), 0);

    // R12 empty snapshot
    fixed_mode = 1'b1; fixed_val = '0;
    idle(10);
    trig(1'b1); idle(2); accept(); idle(5);
    chk("R12 lone trailer", 32'(word_count_o), 1);
    drain();
    fixed_mode = 1'b0;
    idle(2);

    // R2 programmed latency, and zero treated as one
    set_lat(12); idle(15);
    trig(1'b1); idle(2); accept(); idle(40);
    set_lat(0); idle(3);
    trig(1'b1); idle(2); accept(); idle(40);
    set_lat(5); idle(6);
    drain();

    // R8 gate low
    gate_i = 1'b0; l1_trig_i = 1'b1; rej_tb++;
    cyc();
    l1_trig_i = 1'b0;
    idle(1);
    chk("R8 rejected count", 32'(rej_count_o), 32'(rej_tb));
    accept(); idle(5);
    chk("R8 nothing committed", 32'(word_count_o), 0);

    // R6 fast clear beats accept
    trig(1'b1); idle(2);
    fast_clear_i = 1'b1; l2_accept_i = 1'b1;
    void'(pend_q.pop_front());
    cyc();
    fast_clear_i = 1'b0; l2_accept_i = 1'b0;
    idle(5);
    chk("R6 clear writes nothing", 32'(word_count_o), 0);
    trig(1'b1); idle(2); fclear(); idle(3);
    accept(); idle(5);
    chk("R6 queue empty after clear", 32'(word_count_o), 0);

    // R7 missing decision, then R4 numbering continues past dropped events
    trig(1'b1); idle(80);
    void'(pend_q.pop_front());
    accept(); idle(5);
    chk("R7 timed-out event dropped", 32'(word_count_o), 0);
    trig(1'b1); idle(2); accept(); idle(40);
    drain();

    // R9 pending queue full with one capture in flight
    fixed_mode = 1'b1; fixed_val = 32'h8000_0001;
    idle(8);
    for (int k = 0; k < 5; k++) trig(1'b1);
    trig(1'b0);
    chk("R9 rejected count", 32'(rej_count_o), 32'(rej_tb));
    for (int k = 0; k < 5; k++) begin accept(); idle(5); end
    idle(5);
    chk("R9 five events committed", 32'(word_count_o), 32'(exp_count));
    drain();

    // R11 full threshold with maximum-size events
    fixed_val = 32'hFFFF_FFFF;
    idle(8);
    for (int k = 0; k < 61; k++) begin trig(1'b1); idle(2); accept(); idle(36); end
    chk("R11 2013 words not full", 32'(full_o), 0);
    trig(1'b1); idle(2); accept(); idle(36);
    chk("R11 2046 words", 32'(word_count_o), 2046);
    chk("R11 full set", 32'(full_o), 1);
    trig(1'b1); idle(2); accept(); idle(36);
    chk("R11 accept while full dropped", 32'(word_count_o), 2046);
    for (int k = 0; k < 30; k++) rd();
    chk("R11 2016 words still full", 32'(full_o), 1);
    rd();
    chk("R11 2015 words not full", 32'(full_o), 0);
    drain();
    chk("R10 empty after drain", 32'(word_count_o), 0);
    rd(); idle(1);
    chk("R10 empty read gives no valid", 32'(rd_valid_o), 0);
    chk("R3 scoreboard consumed", 32'(sb_q.size()), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule